// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

The aggregator gathers single-bit interrupt request lines from several blocks of a data-acquisition carrier and watches each one for a synchronous rising edge. Every detected edge is recorded in a pending register. A read of that register returns its value and clears it. A separate enable mask decides which sources may raise the interrupt toward the host bridge. The request to the bridge is a positive pulse that lasts exactly one clock.

A sticky debug flag in the top bit of the pending register records that some source fired a second time before software had read the first event. A read that coincides with a new edge loses nothing. The read returns the old value, and the new edge remains pending afterwards.

Top module: `irq_gather`

## Requirements
- R1: Each request input is registered once. A 0-to-1 change between two consecutive clock samples of `req_i[k]` sets pending bit k at that clock edge. A line held high sets the bit only once.
- R2: A read strobe at the pending address returns the register on `bus_rdata` in the same cycle. At the following clock edge it clears pending bits NSRC-1..0 and bit 31.
- R3: An edge on source k in the same cycle as a read of the pending register is not lost. The read returns the value from before the edge, and bit k is set after the edge.
- R4: An edge on source k produces an interrupt pulse only if enable-mask bit k is 1. The pending bit is recorded whatever the mask holds.
- R5: `irq_o` rises at the clock edge that detects an enabled rising edge and stays high for exactly one clock.
- R6: When several enabled edges occur in the same cycle, a single one-clock pulse results.
- R7: Pending bit 31 is set when a source edge arrives while that source's bit is still pending, unless that same cycle reads the register. A read clears bit 31.
- R8: Pending and mask bit k belong to input `req_i[k]`. The fixed assignment, from bit 0 upward, is: transfer done, transfer error, carrier over-temperature, mezzanine over-temperature, input overload, acquisition trigger, shot complete, ID-bus done, clock-synthesiser bus done, and converter-config done.
- R9: The pending register is at word address 0x0083 and the mask register at 0x0084. Both read 0 after reset, and `irq_o` is 0.
- R10: Bits 30..NSRC of both registers read as 0. Writes to the pending register have no effect. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NSRC | Interrupt request lines, one per source |
| bus_addr | input | AW | Word address of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NSRC | Write data; only the source-wide field is held |
| bus_rdata | output | DW | Read data for the addressed register, combinational |
| irq_o | output | 1 | One-clock interrupt pulse toward the host bridge |

## Verification
The assertions take the request lines to be synchronous to `clk`, so one sample per clock is the whole history of an input. They also take a read strobe to last one cycle per read. The stimulus changes inputs only on the falling edge and asserts `bus_rd` for a single cycle per access. It never writes the mask in the same cycle as an edge it checks, because the gating uses the mask value held before that write.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  // source bit assignment (R8)
  localparam int unsigned SRC_XFER_DONE   = 0;
  localparam int unsigned SRC_XFER_ERR    = 1;
  localparam int unsigned SRC_CARR_HOT    = 2;
  localparam int unsigned SRC_MEZZ_HOT    = 3;
  localparam int unsigned SRC_OVERLOAD    = 4;
  localparam int unsigned SRC_ACQ_TRIG    = 5;
  localparam int unsigned SRC_SHOT_DONE   = 6;
  localparam int unsigned SRC_IDBUS_DONE  = 7;
  localparam int unsigned SRC_SYNTH_DONE  = 8;
  localparam int unsigned SRC_CFG_DONE    = 9;
  localparam int unsigned SRC_COUNT       = 10;

  // register word addresses (R9)
  localparam logic [15:0] ADDR_PENDING = 16'h0083;
  localparam logic [15:0] ADDR_ENABLE  = 16'h0084;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end

  assign edge_o = req_i & ~req_q;

  // R1: a detected edge leaves the sampled level high afterwards
  a_r1_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_o) |=> (($past(edge_o) & ~req_q) == '0));
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] edge_i,
  input  logic         clr_i,
  output logic [N-1:0] src_o,
  output logic         ovf_o
);
  // set wins over clear
  function automatic logic [N-1:0] next_pending(input logic [N-1:0] cur,
                                                input logic [N-1:0] ev,
                                                input logic clr);
    return (clr ? '0 : cur) | ev;
  endfunction

  function automatic logic repeat_hit(input logic [N-1:0] cur,
                                      input logic [N-1:0] ev,
                                      input logic clr);
    return (|(cur & ev)) && !clr;
  endfunction

  logic [N-1:0] src_q;
  logic         ovf_q;
  logic         ovf_set;

  assign ovf_set = repeat_hit(src_q, edge_i, clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      src_q <= next_pending(src_q, edge_i, clr_i);
      ovf_q <= clr_i ? 1'b0 : (ovf_q | ovf_set);
    end
  end

  assign src_o = src_q;
  assign ovf_o = ovf_q;

  a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_i) |=> ((src_q & $past(edge_i)) == $past(edge_i)));
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|edge_i)) |=> (src_q == '0 && !ovf_q));
  a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (src_q == $past(edge_i)));
  a_r7_repeat_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(edge_i & src_q)) && !clr_i) |=> ovf_q);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  function automatic logic any_enabled(input logic [N-1:0] ev,
                                       input logic [N-1:0] en);
    return |(ev & en);
  endfunction

  logic fire;
  logic irq_q;

  assign fire = any_enabled(edge_i, mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end

  assign irq_o = irq_q;

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(edge_i & mask_i)) |=> !irq_o);
  a_r5_enabled_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_i & mask_i)) |=> irq_o);
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(edge_i & mask_i)));
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int unsigned NSRC      = irq_gather_pkg::SRC_COUNT,
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 16,
  parameter logic [AW-1:0] PEND_AD = AW'(irq_gather_pkg::ADDR_PENDING),
  parameter logic [AW-1:0] MASK_AD = AW'(irq_gather_pkg::ADDR_ENABLE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o
);
  localparam int unsigned OVF_BIT = DW - 1;

  logic [NSRC-1:0] edge_evt;
  logic [NSRC-1:0] src_q;
  logic            ovf_q;
  logic [NSRC-1:0] mask_q;
  logic            sel_pend;
  logic            sel_mask;
  logic            clr_evt;
  logic            mask_wr_evt;

  assign sel_pend    = (bus_addr == PEND_AD);
  assign sel_mask    = (bus_addr == MASK_AD);
  assign clr_evt     = bus_rd && sel_pend;
  assign mask_wr_evt = bus_wr && sel_mask;

  irq_edge_detect #(.N(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .edge_o(edge_evt)
  );

  irq_src_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_evt), .clr_i(clr_evt),
    .src_o(src_q), .ovf_o(ovf_q)
  );

  irq_pulse_gen #(.N(NSRC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_evt), .mask_i(mask_q),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           mask_q <= '0;
    else if (mask_wr_evt) mask_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_pend) begin
      bus_rdata[NSRC-1:0] = src_q;
      bus_rdata[OVF_BIT]  = ovf_q;
    end else if (sel_mask) begin
      bus_rdata[NSRC-1:0] = mask_q;
    end
  end

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[OVF_BIT-1:NSRC] == '0);
  a_r10_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_evt |=> $stable(mask_q));
  a_r9_mask_written: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_evt |=> (mask_q == $past(bus_wdata)));
endmodule

// File: tb/irq_gather_test.sv
module irq_gather_test;
  localparam int N = 10;
  localparam logic [15:0] PA = 16'h0083;
  localparam logic [15:0] MA = 16'h0084;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  req_i = '0;
  logic [15:0]   bus_addr = '0;
  logic          bus_rd = 0;
  logic          bus_wr = 0;
  logic [N-1:0]  bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench-side expectation
  logic [N-1:0] m_src = '0, m_mask = '0, m_prev = '0;
  logic         m_ovf = 0;

  always #10 clk = ~clk;

  irq_gather uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    if (a == PA) return {m_ovf, 21'd0, m_src};
    if (a == MA) return {22'd0, m_mask};
    return 32'd0;
  endfunction

  // one access cycle followed by one idle cycle
  task automatic step(input logic [N-1:0] req, input bit rd, input bit wr,
                      input logic [15:0] a, input logic [N-1:0] wd, input string tag);
    logic [N-1:0] ev;
    bit clr;
    @(negedge clk);
    chk({tag, " R5 pulse ended"}, {31'd0, irq_o}, 32'd0);
    req_i = req; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    if (rd) chk({tag, " read"}, bus_rdata, exp_read(a));
    ev  = req & ~m_prev;
    clr = rd && (a == PA);
    m_ovf  = clr ? 1'b0 : (m_ovf | (|(ev & m_src)));
    m_src  = (clr ? '0 : m_src) | ev;
    m_prev = req;
    @(negedge clk);
    chk({tag, " R4/R5 irq"}, {31'd0, irq_o}, {31'd0, |(ev & m_mask)});
    if (wr && a == MA) m_mask = wd;
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic rd_pend(input string tag);
    step(req_i, 1, 0, PA, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq reset", {31'd0, irq_o}, 32'd0);
    step('0, 1, 0, PA, '0, "R9 pending reset");
    step('0, 1, 0, MA, '0, "R9 mask reset");
    // R10 reserved bits and ignored writes
    step('0, 0, 1, PA, '1, "R10 pending write");
    step('0, 1, 0, PA, '0, "R10 pending unchanged");
    step('0, 1, 0, 16'h0085, '0, "R10 unmapped");
    step('0, 0, 1, MA, '1, "R10 mask write");
    step('0, 1, 0, MA, '0, "R10 mask readback");
    // R1 R2 R5 R8: every source alone, all enabled
    for (int i = 0; i < N; i++) begin
      step(N'(1) << i, 0, 0, '0, '0, "R1 R5 single edge");
      step('0, 0, 0, '0, '0, "R5 fall");
      rd_pend("R8 R1 pending bit");
      rd_pend("R2 cleared");
    end
    // R4: sweep one enabled source against every input
    for (int j = 0; j < N; j++) begin
      step('0, 0, 1, MA, N'(1) << j, "R4 set mask");
      for (int i = 0; i < N; i++) begin
        step(N'(1) << i, 0, 0, '0, '0, "R4 gated edge");
        step('0, 0, 0, '0, '0, "R4 idle");
        rd_pend("R4 pending regardless");
      end
    end
    // R6 simultaneous edges
    step('0, 0, 1, MA, '1, "R6 mask all");
    step('1, 0, 0, '0, '0, "R6 many edges");
    rd_pend("R6 pending all");
    // R1 level held high does not set again
    rd_pend("R1 held read");
    rd_pend("R1 held stays clear");
    step('0, 0, 0, '0, '0, "R1 release");
    // R3 race for every source
    for (int i = 0; i < N; i++) begin
      step(N'(1) << i, 1, 0, PA, '0, "R3 edge with read");
      rd_pend("R3 bit kept");
      step('0, 0, 0, '0, '0, "R3 drop");
    end
    // R7 repeat flag
    step(10'h004, 0, 0, '0, '0, "R7 first");
    step('0, 0, 0, '0, '0, "R7 drop");
    step(10'h004, 0, 0, '0, '0, "R7 second");
    rd_pend("R7 flag set");
    rd_pend("R7 flag cleared");
    step('0, 0, 0, '0, '0, "R7 drop2");
    step(10'h008, 0, 0, '0, '0, "R7 pend");
    step('0, 0, 0, '0, '0, "R7 drop3");
    step(10'h008, 1, 0, PA, '0, "R7 edge with read");
    rd_pend("R7 no flag on race");
    step('0, 0, 0, '0, '0, "end");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule